// File: doc/BRIEF.md
# Two-Channel Byte DMA Controller

This block copies bytes from one place on a shared data-memory bus to another, for two independent channels. Each channel keeps a byte count, a source address and a destination address. A channel moves one byte each time it is triggered, either by its peripheral request line or by software through a trigger register. After each byte both addresses step up by one and the count steps down by one. When the count reaches zero the channel raises a sticky completion flag. That flag can drive a per-channel interrupt.

The CPU shares the bus and always wins it. While the CPU holds the bus, a DMA transfer simply waits. Each channel remembers only one outstanding trigger, so triggers that arrive while one is already waiting are merged into it. A built-in address decoder recognises a RAM window and a register window. A read from outside both windows yields 0x00 with no bus cycle. A write to outside both windows is dropped.

Software programs a channel while it is disabled, enables it, and then lets requests arrive. Before the channel can run again, software clears the completion flag.

Top module: `dma2_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and neither `bus_rd` nor `bus_wr` is asserted. Register map on `reg_addr`: 0 control (bit0/bit1 channel enables, bit2/bit3 interrupt enables), 1 software trigger (write 1 to bit n), 2 completion flags (bit n, read only), 3 flag clear (write 1 to bit n). Channel n occupies 4+4n for the count, 5+4n for the source address and 6+4n for the destination address.
- R2: Writes to a channel's count, source or destination register are ignored while that channel's enable bit is 1.
- R3: Each trigger of an enabled channel performs one transfer. The transfer reads the byte at the source address and writes it to the destination address, then raises both addresses by one and lowers the count by one.
- R4: With the bus free, a transfer takes four clocks. `bus_rd` is asserted in the second clock after the clock edge that samples the trigger, and `bus_wr` two clocks after that. Triggers four clocks apart are all served.
- R5: When the count reaches 0 the channel's flag becomes 1. While the flag is 1 the channel makes no transfer, even if enabled and triggered. `irq[n]` equals the flag ANDed with the interrupt enable.
- R6: A flag is cleared only by writing 1 to its bit of the clear register. Writing 0 there has no effect.
- R7: `bus_rd` and `bus_wr` are never asserted while `cpu_req` is 1. A transfer in progress waits and completes correctly afterwards.
- R8: A channel holds at most one pending trigger. Several triggers while one is pending, or a hardware and a software trigger in the same clock, give exactly one transfer.
- R9: A source outside the RAM window (0x0100–0x01FF) and the register window (0x0000–0x003F) is read as 0x00 without asserting `bus_rd`. A destination outside both windows produces no `bus_wr`. The count and the addresses still advance.
- R10: When both channels are pending, channel 0 is served before channel 1.
- R11: Clearing a channel's enable during a transfer lets that transfer finish and update the channel registers. After that the registers stay unchanged, and triggers are ignored while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU occupies the data bus this clock |
| hw_req | input | 2 | Peripheral request line per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| bus_rd | output | 1 | DMA read strobe on the data bus |
| bus_wr | output | 1 | DMA write strobe on the data bus |
| bus_addr | output | 16 | DMA bus address |
| bus_wdata | output | 8 | DMA write byte |
| bus_rdata | input | 8 | Read byte, valid the clock after `bus_rd` |
| irq | output | 2 | Per-channel completion interrupt |

## Verification
The assertions rely on two things about the environment. The memory returns read data exactly one clock after `bus_rd`. Register writes to the clear register are single-clock strobes. The bench honours both: its memory model answers on the next edge, and every register access lasts one clock. The flag-stickiness and count-lock properties also assume that only the register port changes the configuration. The stimulus never drives the count or flags any other way. Source regions are never used as destinations, so expected bytes can be computed from the initial memory pattern.

// File: rtl/dma2_pkg.sv
`timescale 1ns/1ps
package dma2_pkg;
  parameter int DMA_NCH = 2;   // channels
  parameter int DMA_AW  = 16;  // bus address and register data width
  parameter int DMA_CW  = 8;   // transfer count width
  parameter int DMA_DW  = 8;   // bus data width
  parameter int DMA_RAW = 4;   // register address width

  localparam logic [DMA_RAW-1:0] RA_CTRL = 4'd0;
  localparam logic [DMA_RAW-1:0] RA_TRIG = 4'd1;
  localparam logic [DMA_RAW-1:0] RA_STAT = 4'd2;
  localparam logic [DMA_RAW-1:0] RA_CLR  = 4'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_LATCH, PH_WRITE} phase_e;

  // first register of channel ch (count), then source, then destination
  function automatic logic [DMA_RAW-1:0] chan_base(input int ch);
    return DMA_RAW'(4 + 4 * ch);
  endfunction

  function automatic logic in_window(input logic [DMA_AW-1:0] a,
                                     input logic [DMA_AW-1:0] base,
                                     input logic [DMA_AW-1:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

  function automatic logic [DMA_CW-1:0] count_after(input logic [DMA_CW-1:0] c);
    return c - DMA_CW'(1);
  endfunction
endpackage

// File: rtl/dma2_chan.sv
`timescale 1ns/1ps
module dma2_chan import dma2_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_cnt,
  input  logic              wr_src,
  input  logic              wr_dst,
  input  logic [DMA_AW-1:0] wdata,
  input  logic              trig,
  input  logic              grant,
  input  logic              done,
  input  logic              clr,
  output logic [DMA_CW-1:0] cnt,
  output logic [DMA_AW-1:0] src,
  output logic [DMA_AW-1:0] dst,
  output logic              sta,
  output logic              ready
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      src  <= '0;
      dst  <= '0;
      sta  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (clr) sta <= 1'b0;
      if (done) begin
        src <= src + DMA_AW'(1);
        dst <= dst + DMA_AW'(1);
        cnt <= count_after(cnt);
        if (cnt == DMA_CW'(1)) sta <= 1'b1;
      end else if (!en) begin
        if (wr_cnt) cnt <= wdata[DMA_CW-1:0];
        if (wr_src) src <= wdata;
        if (wr_dst) dst <= wdata;
      end
      pend <= en && !sta && ((pend && !grant) || trig);
    end
  end

  assign ready = pend && en && !sta && (cnt != '0);
endmodule

// File: rtl/dma2_arb.sv
`timescale 1ns/1ps
module dma2_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic taken;
  always_comb begin
    gnt   = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma2_engine.sv
`timescale 1ns/1ps
module dma2_engine import dma2_pkg::*; #(
  parameter logic [DMA_AW-1:0] RAM_BASE = 16'h0100,
  parameter logic [DMA_AW-1:0] RAM_SIZE = 16'h0100,
  parameter logic [DMA_AW-1:0] SFR_BASE = 16'h0000,
  parameter logic [DMA_AW-1:0] SFR_SIZE = 16'h0040
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic [DMA_NCH-1:0]            grant,
  input  logic [DMA_NCH-1:0][DMA_AW-1:0] src_all,
  input  logic [DMA_NCH-1:0][DMA_AW-1:0] dst_all,
  output logic                          can_start,
  output logic [DMA_NCH-1:0]            done,
  output logic                          bus_rd,
  output logic                          bus_wr,
  output logic [DMA_AW-1:0]             bus_addr,
  output logic [DMA_DW-1:0]             bus_wdata,
  input  logic [DMA_DW-1:0]             bus_rdata
);
  phase_e              ph;
  logic [DMA_NCH-1:0]  owner;
  logic [DMA_AW-1:0]   a_src, a_dst, sel_src, sel_dst;
  logic [DMA_DW-1:0]   byte_q;
  logic                src_ok, dst_ok;

  function automatic logic mapped(input logic [DMA_AW-1:0] a);
    return in_window(a, RAM_BASE, RAM_SIZE) || in_window(a, SFR_BASE, SFR_SIZE);
  endfunction

  always_comb begin
    sel_src = '0;
    sel_dst = '0;
    for (int i = 0; i < DMA_NCH; i++) begin
      if (grant[i]) begin
        sel_src = src_all[i];
        sel_dst = dst_all[i];
      end
    end
  end

  assign src_ok    = mapped(a_src);
  assign dst_ok    = mapped(a_dst);
  assign can_start = (ph == PH_IDLE) && !cpu_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      owner  <= '0;
      a_src  <= '0;
      a_dst  <= '0;
      byte_q <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (|grant) begin
          ph    <= PH_READ;
          owner <= grant;
          a_src <= sel_src;
          a_dst <= sel_dst;
        end
        PH_READ:  if (!cpu_req) ph <= PH_LATCH;
        PH_LATCH: begin
          byte_q <= src_ok ? bus_rdata : '0;
          ph     <= PH_WRITE;
        end
        PH_WRITE: if (!cpu_req) ph <= PH_IDLE;
        default:  ph <= PH_IDLE;
      endcase
    end
  end

  assign bus_rd    = (ph == PH_READ)  && !cpu_req && src_ok;
  assign bus_wr    = (ph == PH_WRITE) && !cpu_req && dst_ok;
  assign bus_addr  = (ph == PH_WRITE) ? a_dst : ((ph == PH_READ) ? a_src : '0);
  assign bus_wdata = byte_q;
  assign done      = owner & {DMA_NCH{(ph == PH_WRITE) && !cpu_req}};
endmodule

// File: rtl/dma2_ctrl.sv
`timescale 1ns/1ps
module dma2_ctrl import dma2_pkg::*; #(
  parameter logic [DMA_AW-1:0] RAM_BASE = 16'h0100,
  parameter logic [DMA_AW-1:0] RAM_SIZE = 16'h0100,
  parameter logic [DMA_AW-1:0] SFR_BASE = 16'h0000,
  parameter logic [DMA_AW-1:0] SFR_SIZE = 16'h0040
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic [DMA_NCH-1:0]  hw_req,
  input  logic                reg_we,
  input  logic [DMA_RAW-1:0]  reg_addr,
  input  logic [DMA_AW-1:0]   reg_wdata,
  output logic [DMA_AW-1:0]   reg_rdata,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic [DMA_AW-1:0]   bus_addr,
  output logic [DMA_DW-1:0]   bus_wdata,
  input  logic [DMA_DW-1:0]   bus_rdata,
  output logic [DMA_NCH-1:0]  irq
);
  localparam int N = DMA_NCH;

  logic [N-1:0]             ctrl_en, ctrl_ie;
  logic [N-1:0]             sw_trig, clr_vec, trig;
  logic [N-1:0]             chan_ready, chan_grant, chan_done, chan_sta, arb_gnt;
  logic [N-1:0][DMA_CW-1:0] cnt_all;
  logic [N-1:0][DMA_AW-1:0] src_all, dst_all;
  logic                     can_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= '0;
      ctrl_ie <= '0;
    end else if (reg_we && reg_addr == RA_CTRL) begin
      ctrl_en <= reg_wdata[N-1:0];
      ctrl_ie <= reg_wdata[2*N-1:N];
    end
  end

  assign sw_trig = (reg_we && reg_addr == RA_TRIG) ? reg_wdata[N-1:0] : '0;
  assign clr_vec = (reg_we && reg_addr == RA_CLR)  ? reg_wdata[N-1:0] : '0;
  assign trig    = hw_req | sw_trig;

  for (genvar g = 0; g < N; g++) begin : g_ch
    dma2_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl_en[g]),
      .wr_cnt (reg_we && reg_addr == chan_base(g)),
      .wr_src (reg_we && reg_addr == chan_base(g) + 4'd1),
      .wr_dst (reg_we && reg_addr == chan_base(g) + 4'd2),
      .wdata  (reg_wdata),
      .trig   (trig[g]),
      .grant  (chan_grant[g]),
      .done   (chan_done[g]),
      .clr    (clr_vec[g]),
      .cnt    (cnt_all[g]),
      .src    (src_all[g]),
      .dst    (dst_all[g]),
      .sta    (chan_sta[g]),
      .ready  (chan_ready[g])
    );
  end

  dma2_arb #(.N(N)) u_arb (.req(chan_ready), .gnt(arb_gnt));
  assign chan_grant = arb_gnt & {N{can_start}};

  dma2_engine #(
    .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE),
    .SFR_BASE(SFR_BASE), .SFR_SIZE(SFR_SIZE)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .grant     (chan_grant),
    .src_all   (src_all),
    .dst_all   (dst_all),
    .can_start (can_start),
    .done      (chan_done),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_CTRL) begin
      reg_rdata[N-1:0]   = ctrl_en;
      reg_rdata[2*N-1:N] = ctrl_ie;
    end
    if (reg_addr == RA_STAT) reg_rdata[N-1:0] = chan_sta;
    for (int i = 0; i < N; i++) begin
      if (reg_addr == chan_base(i))         reg_rdata = DMA_AW'(cnt_all[i]);
      if (reg_addr == chan_base(i) + 4'd1)  reg_rdata = src_all[i];
      if (reg_addr == chan_base(i) + 4'd2)  reg_rdata = dst_all[i];
    end
  end

  assign irq = chan_sta & ctrl_ie;
endmodule

// File: rtl/dma2_checker.sv
`timescale 1ns/1ps
module dma2_checker import dma2_pkg::*; (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_req,
  input logic                          bus_rd,
  input logic                          bus_wr,
  input logic                          reg_we,
  input logic [DMA_RAW-1:0]            reg_addr,
  input logic [DMA_AW-1:0]             reg_wdata,
  input logic [DMA_NCH-1:0]            ctrl_en,
  input logic [DMA_NCH-1:0]            chan_ready,
  input logic [DMA_NCH-1:0]            chan_grant,
  input logic [DMA_NCH-1:0]            chan_done,
  input logic [DMA_NCH-1:0]            chan_sta,
  input logic [DMA_NCH-1:0][DMA_CW-1:0] cnt_all
);
  assert_cpu_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !bus_rd && !bus_wr);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_done[0] |=> cnt_all[0] == DMA_CW'($past(cnt_all[0]) - 1));

  assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_grant));

  assert_ch0_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_grant[1] |-> !chan_ready[0]);

  assert_flag_blocks0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sta[0] |-> !chan_grant[0]);

  assert_flag_blocks1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sta[1] |-> !chan_grant[1]);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sta[0] && !(reg_we && reg_addr == RA_CLR && reg_wdata[0]) |=> chan_sta[0]);

  assert_count_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en[1] && !chan_done[1] |=> $stable(cnt_all[1]));
endmodule

bind dma2_ctrl dma2_checker u_chk (.*);

// File: tb/test_dma2_ctrl.sv
`timescale 1ns/1ps
module test_dma2_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [1:0]  hw_req = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  rdata_q = '0;
  logic [1:0]  irq;

  int n_tests = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, n_viol = 0;
  logic [7:0]  mem [512];
  logic [15:0] rd_log [256];

  always #4 clk = ~clk;

  dma2_ctrl i_dma2_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .hw_req(hw_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_q), .irq(irq)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    if (bus_rd) rdata_q <= mem[bus_addr[8:0]];
    if (bus_wr) mem[bus_addr[8:0]] <= bus_wdata;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rd) begin rd_log[n_rd % 256] = bus_addr; n_rd = n_rd + 1; end
      if (bus_wr) n_wr = n_wr + 1;
      if ((bus_rd || bus_wr) && cpu_req) n_viol = n_viol + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input int ch, input int cnt, input int src, input int dst);
    wr(4'(4 + 4 * ch), 16'(cnt));
    wr(4'(5 + 4 * ch), 16'(src));
    wr(4'(6 + 4 * ch), 16'(dst));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int b_rd, b_wr, bit_m;
    for (int i = 0; i < 512; i++) mem[i] = pat(i);
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), v);
      chk(v == 16'h0, "R1 register reset", v, 0);
    end
    chk(irq == 2'b00, "R1 irq reset", irq, 0);
    chk(n_rd == 0 && n_wr == 0, "R1 bus idle", n_rd + n_wr, 0);

    // R2: configuration locked while enabled (channel 1)
    setup(1, 3, 16'h0150, 16'h01F0);
    wr(0, 16'h0002);
    wr(8, 16'h0055); wr(9, 16'h0111); wr(10, 16'h0122);
    rd(8, v);  chk(v == 16'd3, "R2 count locked", v, 3);
    rd(9, v);  chk(v == 16'h0150, "R2 source locked", v, 16'h0150);
    rd(10, v); chk(v == 16'h01F0, "R2 dest locked", v, 16'h01F0);
    wr(0, 16'h0000);
    wr(8, 16'h0004);
    rd(8, v);  chk(v == 16'd4, "R2 count writable when disabled", v, 4);

    // R3 R4 R5 R6: sweep channels, counts and source windows
    for (int ch = 0; ch < 2; ch++) begin
      for (int cnt = 1; cnt <= 4; cnt++) begin
        for (int k = 0; k < 2; k++) begin
          int src0, dst0;
          bit_m = 1 << ch;
          src0 = (k == 0) ? (16'h0100 + cnt * 8 + ch * 16'h40) : (16'h10 + ch * 16'h10);
          dst0 = 16'h0180 + ch * 16'h20 + cnt * 4;
          wr(0, 16'h0000);
          setup(ch, cnt, src0, dst0);
          wr(0, 16'(bit_m | (bit_m << 2)));
          b_rd = n_rd;
          for (int t = 0; t < cnt; t++) begin
            wr(1, 16'(bit_m));
            tick(1);
            if (t == 0) chk(bus_rd == 1'b1, "R4 read two clocks after trigger", bus_rd, 1);
            tick(2);
            if (t == 0) chk(bus_wr == 1'b1, "R4 write two clocks after read", bus_wr, 1);
          end
          tick(6);
          chk(n_rd - b_rd == cnt, "R4 no trigger lost at 4-clock spacing", n_rd - b_rd, cnt);
          rd(4'(4 + 4 * ch), v); chk(v == 0, "R3 count exhausted", v, 0);
          rd(4'(5 + 4 * ch), v); chk(v == 16'(src0 + cnt), "R3 source advanced", v, src0 + cnt);
          rd(4'(6 + 4 * ch), v); chk(v == 16'(dst0 + cnt), "R3 dest advanced", v, dst0 + cnt);
          for (int i = 0; i < cnt; i++)
            chk(mem[dst0 + i] == pat(src0 + i), "R3 byte copied", mem[dst0 + i], pat(src0 + i));
          rd(2, v); chk(v[ch] == 1'b1, "R5 flag set at zero count", v[ch], 1);
          chk(irq == 2'(bit_m), "R5 irq follows flag", irq, bit_m);
          // R5: blocked while flag set, even with a fresh count
          wr(0, 16'h0000); wr(4'(4 + 4 * ch), 16'd2); wr(0, 16'(bit_m));
          b_rd = n_rd;
          wr(1, 16'(bit_m)); tick(8);
          chk(n_rd == b_rd, "R5 no transfer while flag set", n_rd - b_rd, 0);
          rd(4'(4 + 4 * ch), v); chk(v == 2, "R5 count untouched while flag set", v, 2);
          // R6: clear only by writing 1
          wr(3, 16'h0000); rd(2, v);
          chk(v[ch] == 1'b1, "R6 write 0 keeps flag", v[ch], 1);
          wr(3, 16'(bit_m)); rd(2, v);
          chk(v[ch] == 1'b0, "R6 write 1 clears flag", v[ch], 0);
          wr(0, 16'h0000);
        end
      end
    end

    // R8: merged triggers while the bus is held
    setup(0, 8, 16'h0120, 16'h01C0);
    wr(0, 16'h0001);
    b_rd = n_rd;
    cpu_req = 1'b1;
    wr(1, 16'h0001);
    hw_req = 2'b01; tick(2); hw_req = 2'b00;
    wr(1, 16'h0001);
    tick(3);
    cpu_req = 1'b0;
    tick(10);
    chk(n_rd - b_rd == 1, "R8 merged triggers give one transfer", n_rd - b_rd, 1);
    rd(4, v); chk(v == 7, "R8 count after merge", v, 7);
    b_rd = n_rd;
    hw_req = 2'b01;
    wr(1, 16'h0001);
    hw_req = 2'b00;
    tick(10);
    chk(n_rd - b_rd == 1, "R8 same-clock hw and sw trigger", n_rd - b_rd, 1);
    rd(4, v); chk(v == 6, "R8 count after simultaneous triggers", v, 6);
    wr(0, 16'h0000);

    // R10: channel 0 ahead of channel 1
    setup(0, 1, 16'h0160, 16'h0190);
    setup(1, 1, 16'h0170, 16'h01A8);
    wr(0, 16'h0003);
    b_rd = n_rd;
    cpu_req = 1'b1;
    wr(1, 16'h0003);
    tick(2);
    cpu_req = 1'b0;
    tick(12);
    chk(n_rd - b_rd == 2, "R10 both channels served", n_rd - b_rd, 2);
    chk(rd_log[b_rd % 256] == 16'h0160, "R10 channel 0 first", rd_log[b_rd % 256], 16'h0160);
    chk(rd_log[(b_rd + 1) % 256] == 16'h0170, "R10 channel 1 second", rd_log[(b_rd + 1) % 256], 16'h0170);
    wr(0, 16'h0000); wr(3, 16'h0003);

    // R7: CPU traffic interleaved with transfers
    setup(0, 6, 16'h0140, 16'h01A0);
    wr(0, 16'h0001);
    for (int t = 0; t < 6; t++) begin
      wr(1, 16'h0001);
      for (int c = 0; c < 14; c++) begin
        cpu_req = (c % 3 != 1);
        tick(1);
      end
      cpu_req = 1'b0;
      tick(4);
    end
    rd(4, v); chk(v == 0, "R7 all transfers completed", v, 0);
    for (int i = 0; i < 6; i++)
      chk(mem[16'h01A0 + i] == pat(16'h0140 + i), "R7 data intact under CPU traffic",
          mem[16'h01A0 + i], pat(16'h0140 + i));
    chk(n_viol == 0, "R7 no DMA strobe while CPU holds bus", n_viol, 0);
    wr(0, 16'h0000); wr(3, 16'h0003);

    // R9: unmapped source and destination
    mem[16'h01E0] = 8'hAA; mem[16'h01E1] = 8'hAA;
    setup(1, 2, 16'h0080, 16'h01E0);
    wr(0, 16'h0002);
    b_rd = n_rd; b_wr = n_wr;
    wr(1, 16'h0002); tick(3); wr(1, 16'h0002); tick(8);
    chk(n_rd == b_rd, "R9 no read strobe for unmapped source", n_rd - b_rd, 0);
    chk(n_wr - b_wr == 2, "R9 writes still made", n_wr - b_wr, 2);
    chk(mem[16'h01E0] == 8'h00 && mem[16'h01E1] == 8'h00, "R9 zero byte written",
        mem[16'h01E0], 0);
    wr(0, 16'h0000); wr(3, 16'h0003);
    setup(1, 1, 16'h0110, 16'h0300);
    wr(0, 16'h0002);
    b_rd = n_rd; b_wr = n_wr;
    wr(1, 16'h0002); tick(8);
    chk(n_wr == b_wr, "R9 no write strobe for unmapped dest", n_wr - b_wr, 0);
    chk(n_rd - b_rd == 1, "R9 source still read", n_rd - b_rd, 1);
    rd(10, v); chk(v == 16'h0301, "R9 dest advanced anyway", v, 16'h0301);
    rd(8, v);  chk(v == 0, "R9 count advanced anyway", v, 0);
    wr(0, 16'h0000); wr(3, 16'h0003);

    // R11: disable in the middle of a transfer
    setup(0, 4, 16'h0130, 16'h01D0);
    wr(0, 16'h0001);
    wr(1, 16'h0001);
    for (int w = 0; w < 10 && !bus_rd; w++) tick(1);
    wr(0, 16'h0000);
    tick(8);
    rd(4, v); chk(v == 3, "R11 in-flight transfer finished count", v, 3);
    rd(5, v); chk(v == 16'h0131, "R11 in-flight source", v, 16'h0131);
    rd(6, v); chk(v == 16'h01D1, "R11 in-flight dest", v, 16'h01D1);
    chk(mem[16'h01D0] == pat(16'h0130), "R11 in-flight byte", mem[16'h01D0], pat(16'h0130));
    b_rd = n_rd;
    wr(1, 16'h0001); hw_req = 2'b01; tick(1); hw_req = 2'b00; tick(8);
    chk(n_rd == b_rd, "R11 triggers ignored while disabled", n_rd - b_rd, 0);
    rd(4, v); chk(v == 3, "R11 count held after disable", v, 3);
    rd(2, v); chk(v[0] == 1'b0, "R11 no flag after disable", v[0], 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule